// File: doc/BRIEF.md
# Receive Frame Status and Overflow Statistics

This block follows one received Ethernet frame at a time, from a start-of-frame strobe to an end-of-frame strobe. While the frame is in flight it counts valid bytes, remembers the low bit of the first byte (the first destination-address byte), and collects condition pulses from neighbouring logic: CRC failure, physical-layer error, late collision and receive-buffer overflow. When the frame ends, it folds these into one 8-bit status byte. That byte stays visible to the host until the next frame ends.

Alongside the per-frame byte, it keeps a 7-bit statistic that counts frames damaged by buffer overflow. A sticky flag records that this counter has wrapped. The counter and the flag read as one 8-bit word, and a host read pulse clears both. If an increment lands in the same cycle as the read, the increment is not lost.

The inputs are pulses produced elsewhere. This block does not compute the CRC, filter addresses or hold the buffer.

Top module: `rx_frame_status`

## Requirements
- R1: After reset `status_o` is 0x00 and `cnt_o` is 0x00.
- R2: `status_o` changes only on the clock edge that samples `eof_i` high inside a frame. At every other time it holds the value taken at the last frame end.
- R3: Bit 7 of the status is 1 when the frame held fewer than MIN_BYTES valid bytes (default 64), counting the start and end cycles. At exactly MIN_BYTES the bit is 0.
- R4: Bit 6 of the status equals bit 0 of the first valid byte of the frame, i.e. the multicast marker of the destination address.
- R5: Bit 5 is 1 when `late_col_i` pulsed in any cycle from start-of-frame through end-of-frame. A pulse that comes before `sof_i` does not carry into the frame.
- R6: Bit 4 is 1 when the frame held more than MAX_BYTES valid bytes (default 2048). At exactly MAX_BYTES the bit is 0. The internal count saturates, so very long frames keep the bit set.
- R7: Bit 3 reports `phy_err_i`, bit 1 reports `crc_err_i` and bit 0 reports `ovf_i`. Each is set by a pulse anywhere within the frame.
- R8: Bit 2 is 1 when `tail_bits_i` is nonzero in the end-of-frame cycle, meaning the frame stopped mid-byte.
- R9: `cnt_o[6:0]` increases by one for each completed frame whose status bit 0 is set. Otherwise it stays constant while no read occurs.
- R10: When `cnt_o[6:0]` steps from 127 it becomes 0 and `cnt_o[7]` becomes 1. Bit 7 stays 1 until a read.
- R11: A one-cycle `cnt_rd_i` pulse presents the current value on `cnt_o` in that cycle and leaves `cnt_o` at 0x00 in the next cycle.
- R12: When a read and an increment occur in the same cycle, `cnt_o` becomes 0x01 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start-of-frame strobe; may carry the first byte |
| byte_vld_i | input | 1 | A received byte is present this cycle |
| byte_i | input | 8 | Received byte |
| eof_i | input | 1 | End-of-frame strobe; may carry the last byte |
| tail_bits_i | input | 3 | Leftover bit count at frame end |
| crc_err_i | input | 1 | CRC failure pulse |
| phy_err_i | input | 1 | Physical-layer error pulse |
| late_col_i | input | 1 | Late collision pulse |
| ovf_i | input | 1 | Receive buffer overflow pulse |
| cnt_rd_i | input | 1 | Host read strobe for the overflow statistic |
| status_o | output | 8 | Status byte of the last completed frame |
| cnt_o | output | 8 | {wrap flag, overflow frame count} |

## Verification
The hardest situation to reach from the ports is the wrap of the overflow statistic. It takes 128 separate damaged frames after a clear. The stimulus reaches it by sending one-byte frames that carry an overflow pulse in their only cycle, which keeps the run short. The coincidence of a read with an increment also has to be set up deliberately. The bench first leaves the counter at a nonzero value and then raises the read strobe in exactly the end-of-frame cycle of an overflow frame. It then confirms that the result is one, rather than zero or the old value plus one.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
   // Status byte layout; the host decodes these positions.
   localparam int ST_RUNT  = 7;
   localparam int ST_MCAST = 6;
   localparam int ST_LATE  = 5;
   localparam int ST_LONG  = 4;
   localparam int ST_PHY   = 3;
   localparam int ST_ALIGN = 2;
   localparam int ST_CRC   = 1;
   localparam int ST_OVF   = 0;
   localparam int ST_W     = 8;

   // Order of condition pulses on the accumulator input vector.
   localparam int C_CRC  = 0;
   localparam int C_PHY  = 1;
   localparam int C_LATE = 2;
   localparam int C_OVF  = 3;
   localparam int N_COND = 4;
endpackage

// File: rtl/rfs_byte_meter.sv
module rfs_byte_meter #(
   parameter int MIN_BYTES = 64,
   parameter int MAX_BYTES = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sof_i,
   input  logic byte_vld_i,
   output logic short_o,
   output logic long_o
);
   localparam int LEN_W = $clog2(MAX_BYTES + 2);
   localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_BYTES + 1);
   localparam logic [LEN_W-1:0] LOW = LEN_W'(MIN_BYTES);
   localparam logic [LEN_W-1:0] HIGH = LEN_W'(MAX_BYTES);

   logic [LEN_W-1:0] len_q, base, len_nx;

   always_comb begin
      base   = sof_i ? '0 : len_q;
      len_nx = (byte_vld_i && (base != CAP)) ? base + 1'b1 : base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) len_q <= '0;
      else        len_q <= len_nx;
   end

   // Verdicts include the byte of the current cycle.
   assign short_o = (len_nx < LOW);
   assign long_o  = (len_nx > HIGH);
endmodule

// File: rtl/rfs_flag_acc.sv
module rfs_flag_acc #(
   parameter int N_FLAG    = 4,
   parameter int MCAST_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic              byte_vld_i,
   input  logic [7:0]        byte_i,
   input  logic [N_FLAG-1:0] pulse_i,
   output logic [N_FLAG-1:0] flag_o,
   output logic              mcast_o
);
   for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
      logic seen_q, seen_now;
      assign seen_now = (sof_i ? 1'b0 : seen_q) | pulse_i[g];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) seen_q <= 1'b0;
         else        seen_q <= seen_now;
      end
      assign flag_o[g] = seen_now;
   end

   logic got_q, mc_q, got_b;
   assign got_b   = sof_i ? 1'b0 : got_q;
   assign mcast_o = got_b ? mc_q : (byte_vld_i & byte_i[MCAST_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got_q <= 1'b0;
         mc_q  <= 1'b0;
      end else begin
         got_q <= got_b | byte_vld_i;
         mc_q  <= mcast_o;
      end
   end
endmodule

// File: rtl/rfs_ovf_stat.sv
module rfs_ovf_stat #(
   parameter int CNT_W = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           inc_i,
   input  logic           rd_i,
   output logic [CNT_W:0] stat_o
);
   logic [CNT_W-1:0] cnt_q, cnt_b, sum;
   logic             wrap_q, wrap_b, carry;

   always_comb begin
      cnt_b          = rd_i ? '0 : cnt_q;
      wrap_b         = rd_i ? 1'b0 : wrap_q;
      {carry, sum}   = {1'b0, cnt_b} + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         wrap_q <= 1'b0;
      end else if (inc_i) begin
         cnt_q  <= sum;
         wrap_q <= wrap_b | carry;
      end else begin
         cnt_q  <= cnt_b;
         wrap_q <= wrap_b;
      end
   end

   assign stat_o = {wrap_q, cnt_q};
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status #(
   parameter int MIN_BYTES = 64,
   parameter int MAX_BYTES = 2048,
   parameter int CNT_W     = 7,
   parameter int MCAST_BIT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sof_i,
   input  logic         byte_vld_i,
   input  logic [7:0]   byte_i,
   input  logic         eof_i,
   input  logic [2:0]   tail_bits_i,
   input  logic         crc_err_i,
   input  logic         phy_err_i,
   input  logic         late_col_i,
   input  logic         ovf_i,
   input  logic         cnt_rd_i,
   output logic [7:0]   status_o,
   output logic [CNT_W:0] cnt_o
);
   import rfs_pkg::*;

   if (MIN_BYTES < 1 || MIN_BYTES >= MAX_BYTES) begin : g_bad_len
      $error("rx_frame_status: MIN_BYTES must be in 1..MAX_BYTES-1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("rx_frame_status: CNT_W must be at least 1");
   end
   if (MCAST_BIT < 0 || MCAST_BIT > 7) begin : g_bad_mc
      $error("rx_frame_status: MCAST_BIT out of byte range");
   end

   logic              short_w, long_w, mcast_w, done_w, active_q;
   logic [N_COND-1:0] pulses, flags;
   logic [ST_W-1:0]   status_q, status_nx;

   assign pulses[C_CRC]  = crc_err_i;
   assign pulses[C_PHY]  = phy_err_i;
   assign pulses[C_LATE] = late_col_i;
   assign pulses[C_OVF]  = ovf_i;

   rfs_byte_meter #(.MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES)) u_meter (
      .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
      .short_o(short_w), .long_o(long_w));

   rfs_flag_acc #(.N_FLAG(N_COND), .MCAST_BIT(MCAST_BIT)) u_flags (
      .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
      .byte_i(byte_i), .pulse_i(pulses), .flag_o(flags), .mcast_o(mcast_w));

   assign done_w = eof_i & (active_q | sof_i);

   always_comb begin
      status_nx           = '0;
      status_nx[ST_RUNT]  = short_w;
      status_nx[ST_MCAST] = mcast_w;
      status_nx[ST_LATE]  = flags[C_LATE];
      status_nx[ST_LONG]  = long_w;
      status_nx[ST_PHY]   = flags[C_PHY];
      status_nx[ST_ALIGN] = |tail_bits_i;
      status_nx[ST_CRC]   = flags[C_CRC];
      status_nx[ST_OVF]   = flags[C_OVF];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         status_q <= '0;
      end else begin
         if (sof_i)       active_q <= ~eof_i;
         else if (eof_i)  active_q <= 1'b0;
         if (done_w)      status_q <= status_nx;
      end
   end

   assign status_o = status_q;

   rfs_ovf_stat #(.CNT_W(CNT_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .inc_i(done_w & flags[C_OVF]),
      .rd_i(cnt_rd_i), .stat_o(cnt_o));
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
   parameter int CNT_W = 7
) (
   input logic           clk,
   input logic           rst_n,
   input logic           eof_i,
   input logic           cnt_rd_i,
   input logic [7:0]     status_o,
   input logic [CNT_W:0] cnt_o
);
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !eof_i |=> $stable(status_o)); // R2
   AST_SHORT_LONG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({status_o[7], status_o[4]})); // R6
   AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_rd_i && !eof_i) |=> $stable(cnt_o)); // R9
   AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_rd_i && cnt_o[CNT_W]) |=> cnt_o[CNT_W]); // R10
   AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rd_i && !eof_i) |=> (cnt_o == '0)); // R11
   AST_READ_INC: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rd_i |=> (cnt_o <= (CNT_W+1)'(1))); // R12
endmodule

bind rx_frame_status rfs_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .eof_i(eof_i), .cnt_rd_i(cnt_rd_i),
   .status_o(status_o), .cnt_o(cnt_o));

// File: tb/tb_rx_frame_status.sv
module tb_rx_frame_status;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sof_i = 0, byte_vld_i = 0, eof_i = 0, cnt_rd_i = 0;
   logic [7:0] byte_i = '0;
   logic [2:0] tail_bits_i = '0;
   logic crc_err_i = 0, phy_err_i = 0, late_col_i = 0, ovf_i = 0;
   logic [7:0] status_o, cnt_o;

   int checks = 0, fails = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_frame_status dut (
      .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
      .byte_i(byte_i), .eof_i(eof_i), .tail_bits_i(tail_bits_i),
      .crc_err_i(crc_err_i), .phy_err_i(phy_err_i), .late_col_i(late_col_i),
      .ovf_i(ovf_i), .cnt_rd_i(cnt_rd_i), .status_o(status_o), .cnt_o(cnt_o));

   // {bytes[11:0], first[7:0], tail[2:0], crc, phy, late, ovf, expected[7:0]}
   localparam int NV = 9;
   localparam logic [34:0] VEC [NV] = '{
      {12'd64,   8'h00, 3'd0, 4'b0000, 8'h00},  // R3 boundary
      {12'd63,   8'h01, 3'd0, 4'b0000, 8'hC0},  // R3 R4
      {12'd100,  8'h02, 3'd0, 4'b1000, 8'h02},  // R7 crc
      {12'd80,   8'h03, 3'd5, 4'b0100, 8'h4C},  // R7 phy, R8
      {12'd70,   8'h10, 3'd0, 4'b0010, 8'h20},  // R5
      {12'd2048, 8'h00, 3'd0, 4'b0000, 8'h00},  // R6 boundary
      {12'd2049, 8'hFF, 3'd0, 4'b0000, 8'h50},  // R6 R4
      {12'd10,   8'h00, 3'd1, 4'b1001, 8'h87},  // R7 R8 R3
      {12'd3000, 8'h00, 3'd0, 4'b0001, 8'h11}   // R6 saturation
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic send_frame(input int n, input logic [7:0] first, input logic [2:0] tail,
                             input logic [3:0] cond, input bit rd_at_end);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sof_i       = (i == 0);
         byte_vld_i  = 1'b1;
         byte_i      = (i == 0) ? first : 8'(i * 2);
         eof_i       = (i == n - 1);
         tail_bits_i = (i == n - 1) ? tail : 3'd0;
         {crc_err_i, phy_err_i, late_col_i, ovf_i} = (i == n / 2) ? cond : 4'b0000;
         cnt_rd_i    = rd_at_end && (i == n - 1);
      end
      @(negedge clk);
      sof_i = 0; byte_vld_i = 0; eof_i = 0; tail_bits_i = '0; cnt_rd_i = 0;
      {crc_err_i, phy_err_i, late_col_i, ovf_i} = 4'b0000;
   endtask

   task automatic read_cnt(input string req, input logic [7:0] exp);
      @(negedge clk);
      cnt_rd_i = 1'b1;
      #1 check(req, cnt_o, exp);
      @(negedge clk);
      cnt_rd_i = 1'b0;
      check("R11", cnt_o, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", status_o, 8'h00);
      check("R1", cnt_o, 8'h00);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         send_frame(int'(VEC[v][34:23]), VEC[v][22:15], VEC[v][14:12],
                    VEC[v][11:8], 1'b0);
         check($sformatf("R3-R8 vec%0d", v), status_o, VEC[v][7:0]);
      end

      // R9: two vectors carried overflow
      check("R9", cnt_o, 8'h02);
      // R2: status held while idle
      repeat (5) @(negedge clk);
      check("R2", status_o, 8'h11);
      read_cnt("R11", 8'h02);

      // R5: late collision pulse before start-of-frame must not count
      @(negedge clk); late_col_i = 1'b1;
      @(negedge clk); late_col_i = 1'b0;
      send_frame(64, 8'h00, 3'd0, 4'b0000, 1'b0);
      check("R5", status_o, 8'h00);

      // R10: wrap of the statistic
      for (int k = 0; k < 127; k++) send_frame(1, 8'h00, 3'd0, 4'b0001, 1'b0);
      check("R9", cnt_o, 8'h7F);
      check("R3", status_o, 8'h81);
      send_frame(1, 8'h00, 3'd0, 4'b0001, 1'b0);
      check("R10", cnt_o, 8'h80);
      send_frame(1, 8'h00, 3'd0, 4'b0001, 1'b0);
      check("R10", cnt_o, 8'h81);
      read_cnt("R10", 8'h81);

      // R12: read coincides with increment
      send_frame(4, 8'h00, 3'd0, 4'b0001, 1'b0);
      check("R9", cnt_o, 8'h01);
      send_frame(4, 8'h00, 3'd0, 4'b0001, 1'b1);
      check("R12", cnt_o, 8'h01);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule